// File: doc/BRIEF.md
# Contention-Aware Memory Port Sequencer

This block sits between a simple host request interface and one port of a shared dual-port memory that resolves collisions itself. The host asks for one read or write at a time, giving an address, write data and per-byte enables. The sequencer drives the memory port's select line, per-byte write strobes, address and write data. It watches the port's contention flag, which means "not ready", and turns each request into a short fixed sequence of port cycles.

The sequence runs through six named states. **IDLE** raises `host_ready`, keeps the port deselected and takes in a request. **SETUP** presents the address with the port selected and the write strobes held low for one cycle, so that the contention flag can be sampled before any write begins. **ACCESS** performs the operation. **WAIT** holds the port while contention lasts. **EXTEND** repeats the interrupted operation once more after contention clears. **DONE** pulses `host_ack`.

The transitions are as follows. IDLE→SETUP happens on a request. SETUP→ACCESS and ACCESS→DONE happen when the flag is low. SETUP→WAIT, ACCESS→WAIT and EXTEND→WAIT happen when the flag is high. WAIT→WAIT repeats while the flag stays high, and WAIT→EXTEND follows once it is low. EXTEND→DONE happens when the flag is low, and DONE→IDLE always follows.

Top module: `busy_port_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, the block is in IDLE: `host_ready`=1, `port_ce`=0, `port_we`=0, `host_ack`=0, `host_rdata`=0.
- R2: A request is taken only in IDLE with `req_valid`=1. Address, data, direction and byte enables are registered at that edge. `host_ready` is 0 in every other state, and changes to the request inputs after acceptance do not alter the port outputs.
- R3: The first cycle after acceptance is SETUP. In it `port_ce`=1, `port_addr` shows the request address, and `port_we`=0.
- R4: With the flag low throughout, a request is acknowledged in the third cycle after the accepting edge (SETUP, ACCESS, DONE).
- R5: `port_we` is non-zero only in a cycle entered from a cycle in which `port_busy` was sampled low.
- R6: While `port_busy` is high outside DONE, the next cycle keeps `port_ce`=1 with `port_addr` and `port_wdata` unchanged, and `host_ack` stays low.
- R7: After contention, the first cycle in which the flag is seen low ends the wait. One EXTEND cycle then repeats the operation, and DONE follows.
- R8: On reads, `host_rdata` holds `port_rdata` as sampled at the end of the ACCESS or EXTEND cycle in which the flag was low. Data present while the flag was high is discarded.
- R9: `host_ack` is high for exactly one cycle, and the next cycle is IDLE.
- R10: `port_ce` is 0 in every IDLE cycle, which releases the word at the port.
- R11: `port_we` has one bit per byte lane, and lane i covers data bits [8i+7:8i]. On a write in ACCESS or EXTEND, bit i equals the request's byte enable i. Reads never raise any bit.
- R12: If the flag is high again during EXTEND, the block returns to WAIT and runs a further EXTEND before DONE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte enables for writes |
| host_ready | output | 1 | High in IDLE, where a request can be taken |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | DATA_W | Read result, valid from the acknowledge onward |
| port_ce | output | 1 | Memory port select, active high |
| port_we | output | DATA_W/8 | Per-lane write strobes, active high |
| port_addr | output | ADDR_W | Memory port address |
| port_wdata | output | DATA_W | Memory port write data |
| port_rdata | input | DATA_W | Memory port read data |
| port_busy | input | 1 | Contention flag from the memory, high = lost arbitration |

## Verification
The bench places contention in SETUP, in ACCESS, across several WAIT cycles and again in EXTEND, and counts acknowledge latency and write-strobe cycles in each case. A design that finishes straight after the flag drops acknowledges one cycle early. A design that skips SETUP or checks the flag too late drives a write strobe right after a busy cycle. Read data is made deliberately wrong whenever the flag is high, so a design that captures during contention returns the inverted word. The request inputs are scrambled and `req_valid` is held high during each transfer, so a design that accepts outside IDLE or does not latch the request moves the port address.

// File: rtl/bps_pkg.sv
package bps_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACCESS,
        ST_WAIT,
        ST_EXTEND,
        ST_DONE
    } bps_state_e;
endpackage

// File: rtl/bps_fsm.sv
module bps_fsm
    import bps_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic port_busy,
    output logic ready,
    output logic accept,
    output logic ce,
    output logic we_en,
    output logic capture,
    output logic ack
);
    bps_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_SETUP;
            ST_SETUP:  state_d = port_busy ? ST_WAIT : ST_ACCESS;
            ST_ACCESS: state_d = port_busy ? ST_WAIT : ST_DONE;
            ST_WAIT:   state_d = port_busy ? ST_WAIT : ST_EXTEND;
            ST_EXTEND: state_d = port_busy ? ST_WAIT : ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ready   = 1'b0;
        ce      = 1'b1;
        we_en   = 1'b0;
        capture = 1'b0;
        ack     = 1'b0;
        unique case (state_q)
            ST_IDLE:   begin ready = 1'b1; ce = 1'b0; end
            ST_SETUP:  ;
            ST_ACCESS: begin we_en = 1'b1; capture = 1'b1; end
            ST_WAIT:   ;
            ST_EXTEND: begin we_en = 1'b1; capture = 1'b1; end
            ST_DONE:   ack = 1'b1;
            default:   begin ready = 1'b0; ce = 1'b0; end
        endcase
    end

    assign accept = ready & req_valid;
endmodule

// File: rtl/bps_req_latch.sv
module bps_req_latch #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    output logic              lat_write,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [DATA_W-1:0] lat_wdata,
    output logic [LANES-1:0]  lat_be
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_write <= 1'b0;
            lat_addr  <= '0;
            lat_wdata <= '0;
            lat_be    <= '0;
        end else if (accept) begin
            lat_write <= req_write;
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
            lat_be    <= req_be;
        end
    end
endmodule

// File: rtl/bps_rd_capture.sv
module bps_rd_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              is_write,
    input  logic              port_busy,
    input  logic [DATA_W-1:0] port_rdata,
    output logic [DATA_W-1:0] rdata_q
);
    // a sample taken while the flag is high is never kept
    always_ff @(posedge clk) begin
        if (!rst_n)                              rdata_q <= '0;
        else if (capture && !is_write && !port_busy) rdata_q <= port_rdata;
    end
endmodule

// File: rtl/busy_port_seq.sv
module busy_port_seq #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 16,
    parameter int LANE_W = 8,
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    output logic              host_ready,
    output logic              host_ack,
    output logic [DATA_W-1:0] host_rdata,
    output logic              port_ce,
    output logic [LANES-1:0]  port_we,
    output logic [ADDR_W-1:0] port_addr,
    output logic [DATA_W-1:0] port_wdata,
    input  logic [DATA_W-1:0] port_rdata,
    input  logic              port_busy
);
    logic accept, we_en, capture, lat_write;
    logic [LANES-1:0] lat_be;

    bps_fsm fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .port_busy (port_busy),
        .ready     (host_ready),
        .accept    (accept),
        .ce        (port_ce),
        .we_en     (we_en),
        .capture   (capture),
        .ack       (host_ack)
    );

    bps_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) latch_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_be    (req_be),
        .lat_write (lat_write),
        .lat_addr  (port_addr),
        .lat_wdata (port_wdata),
        .lat_be    (lat_be)
    );

    bps_rd_capture #(.DATA_W(DATA_W)) cap_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (capture),
        .is_write   (lat_write),
        .port_busy  (port_busy),
        .port_rdata (port_rdata),
        .rdata_q    (host_rdata)
    );

    // per-lane write strobes (R11)
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign port_we[g] = we_en & lat_write & lat_be[g];
    end
endmodule

// File: rtl/busy_port_seq_chk.sv
module busy_port_seq_chk #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              host_ready,
    input logic              host_ack,
    input logic              port_ce,
    input logic [LANES-1:0]  port_we,
    input logic [ADDR_W-1:0] port_addr,
    input logic [DATA_W-1:0] port_wdata,
    input logic              port_busy
);
    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready && req_valid |=> port_ce && !host_ready);

    assert_setup_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(port_ce) |-> port_we == '0);

    assert_we_after_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (port_we != '0) |-> !$past(port_busy));

    assert_hold_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        port_busy && port_ce && !host_ack |=>
            port_ce && $stable(port_addr) && $stable(port_wdata) && !host_ack);

    assert_ack_after_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> !$past(port_busy));

    assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack && host_ready);

    assert_idle_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> !port_ce && port_we == '0);
endmodule

bind busy_port_seq busy_port_seq_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .host_ready (host_ready),
    .host_ack   (host_ack),
    .port_ce    (port_ce),
    .port_we    (port_we),
    .port_addr  (port_addr),
    .port_wdata (port_wdata),
    .port_busy  (port_busy)
);

// File: tb/busy_port_seq_tb_top.sv
module busy_port_seq_tb_top;
    localparam int AW = 11;
    localparam int DW = 16;
    localparam int BW = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [BW-1:0] req_be = '0;
    logic host_ready, host_ack, port_ce;
    logic [DW-1:0] host_rdata, port_wdata;
    logic [DW-1:0] port_rdata = '0;
    logic [BW-1:0] port_we;
    logic [AW-1:0] port_addr;
    logic port_busy = 1'b0;

    int n_run = 0;
    int n_fail = 0;

    busy_port_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .host_ready(host_ready), .host_ack(host_ack), .host_rdata(host_rdata),
        .port_ce(port_ce), .port_we(port_we), .port_addr(port_addr),
        .port_wdata(port_wdata), .port_rdata(port_rdata), .port_busy(port_busy)
    );

    typedef struct packed {
        logic          wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [BW-1:0] be;
        logic [15:0]   mask;   // bit c = flag high during cycle c after accept
        logic [4:0]    lat;    // cycle of the acknowledge
        logic [1:0]    wecnt;  // cycles with any write strobe
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b1, 11'h005, 16'hA55A, 2'b11, 16'h0000, 5'd3, 2'd1}, // clean write
        '{1'b0, 11'h7FF, 16'h1234, 2'b11, 16'h0000, 5'd3, 2'd0}, // clean read
        '{1'b1, 11'h100, 16'hBEEF, 2'b01, 16'h0002, 5'd4, 2'd1}, // busy in SETUP
        '{1'b0, 11'h2A0, 16'hC0DE, 2'b10, 16'h000E, 5'd6, 2'd0}, // long wait
        '{1'b1, 11'h033, 16'h5A5A, 2'b10, 16'h0004, 5'd5, 2'd2}, // busy in ACCESS
        '{1'b0, 11'h400, 16'h0F0F, 2'b01, 16'h000C, 5'd6, 2'd0}, // busy in ACCESS, read
        '{1'b1, 11'h0AA, 16'h9669, 2'b11, 16'h000A, 5'd6, 2'd2}, // R12: busy in EXTEND
        '{1'b0, 11'h000, 16'hFFFF, 2'b00, 16'h0000, 5'd3, 2'd0}  // read, no lanes
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input string lat_tag);
        int lat = 0;
        int wes = 0;
        bit prevb = 1'b0;
        bit we_ok = 1'b1;
        bit hold_ok = 1'b1;
        bit setup_ok = 1'b1;
        @(negedge clk);
        check(host_ready == 1'b1, "R2", "ready before request", 32'(host_ready), 1);
        req_valid = 1'b1; req_write = v.wr; req_addr = v.addr;
        req_wdata = v.data; req_be = v.be;
        for (int cyc = 1; cyc < 40; cyc++) begin
            @(negedge clk);
            if (cyc == 1 && (!port_ce || port_we != '0)) setup_ok = 1'b0;
            if (port_we != '0) begin
                wes++;
                if (prevb || !v.wr || port_we != v.be) we_ok = 1'b0;
            end
            if (!port_ce || host_ready || port_addr != v.addr ||
                (v.wr && port_wdata != v.data)) hold_ok = 1'b0;
            if (host_ack) begin lat = cyc; break; end
            // keep a different request pending: must not be taken (R2)
            req_addr = ~v.addr; req_wdata = ~v.data; req_write = ~v.wr;
            prevb = (cyc < 16) ? v.mask[cyc] : 1'b0;
            port_busy = prevb;
            port_rdata = prevb ? ~v.data : v.data;
        end
        req_valid = 1'b0;
        port_busy = 1'b0;
        check(setup_ok, "R3", "SETUP ce/we", {port_ce, port_we}, 32'h4);
        check(lat == int'(v.lat), lat_tag, "ack latency", lat, v.lat);
        check(wes == int'(v.wecnt), "R11", "strobe cycles", wes, v.wecnt);
        check(we_ok, "R5", "strobe after busy or wrong lanes", port_we, v.be);
        check(hold_ok, "R6", "port held during transfer", port_addr, v.addr);
        if (!v.wr)
            check(host_rdata == v.data, "R8", "read data", host_rdata, v.data);
        @(negedge clk);
        check(!host_ack && host_ready, "R9", "single ack then IDLE",
              {host_ack, host_ready}, 32'h1);
        check(!port_ce && port_we == '0, "R10", "deselected in IDLE", port_ce, 0);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(host_ready && !port_ce && port_we == '0 && !host_ack && host_rdata == '0,
              "R1", "reset state", {host_ready, port_ce, host_ack}, 32'h4);
        rst_n = 1'b1;
        @(negedge clk);
        check(host_ready && !port_ce, "R1", "first cycle after reset",
              {host_ready, port_ce}, 32'h2);
        repeat (3) @(negedge clk);
        check(!port_ce && host_ready, "R10", "idle without request", port_ce, 0);

        for (int i = 0; i < 8; i++) begin
            string tag;
            tag = (VECS[i].mask == 16'h0) ? "R4" : ((i == 6) ? "R12" : "R7");
            run_vec(VECS[i], tag);
        end

        // R1: reset in the middle of a contended transfer
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 11'h321;
        req_wdata = 16'h7777; req_be = 2'b11;
        @(negedge clk);
        req_valid = 1'b0; port_busy = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        port_busy = 1'b0; rst_n = 1'b1;
        @(negedge clk);
        check(host_ready && !port_ce && !host_ack, "R1", "reset mid-transfer",
              {host_ready, port_ce}, 32'h2);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule